// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits on a processor's memory-mapped bus and lets software ask an external link engine to read or write one register inside an audio codec. Software loads the codec register number and, for a write, the outgoing value. It then writes the control word with the request bit set and the direction bit chosen. The block raises one of two interrupt pulses, chosen by direction. It also raises a request line toward the link engine and holds it until the engine reports completion.

The request bit never stays set in storage: the control word always reads back with bit 0 clear. The data-in word is a plain storage location that software or a debug path may fill. The block does not format the serial link and does not time the codec's answers.

Top module: `codec_reg_ctrl`

## Requirements
- R1: The word index is the byte address shifted right by two. Index 0 is control, 1 is codec register address, 2 is data out and 3 is data in. Read data appears on `bus_rdata` in the cycle after the read is presented and holds until the next read.
- R2: Writes to the address, data-out and data-in words are stored unchanged and read back unchanged.
- R3: A control write stores the written value with bit 0 forced to 0 and all other bits kept.
- R4: A control write with bit 0 = 1 and bit 1 = 1 makes `irq_wr_req` high for exactly the one cycle after the write.
- R5: A control write with bit 0 = 1 and bit 1 = 0 makes `irq_rd_reply` high for exactly the one cycle after the write.
- R6: A control write with bit 0 = 0 pulses neither interrupt and does not start a link request.
- R7: Only full-word accesses count. These have all four byte enables set and address bits [1:0] equal to 0. Any other write changes nothing, and any other read returns zero.
- R8: Reads from an index above 3 return zero. Writes to such an index change no register.
- R9: Synchronous active-high reset clears all four words, `bus_rdata`, both interrupts and the link request.
- R10: A requesting control write (bit 0 = 1) sets `link_req` in the next cycle and loads `link_dir` with bit 1. `link_req` stays high until a cycle with `link_done` high and no new request, after which it is low.
- R11: The two interrupt outputs are never high in the same cycle.
- R12: `link_addr` and `link_wdata` show the stored codec address and data-out words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_be | input | DATA_W/8 (4) | Byte enables; all must be set |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_wr_req | output | 1 | One-cycle pulse for a codec write request |
| irq_rd_reply | output | 1 | One-cycle pulse for a codec read request |
| link_req | output | 1 | Request toward the link engine |
| link_dir | output | 1 | 1 = codec write, 0 = codec read |
| link_addr | output | DATA_W (32) | Stored codec register address |
| link_wdata | output | DATA_W (32) | Stored data-out word |
| link_done | input | 1 | Link engine finished the request |

## Verification
On every cycle the assertions check several things. The control word keeps bit 0 clear after each accepted write. Each interrupt pulse traces back to a matching control write one cycle earlier, and the two pulses never coincide. Rejected reads return zero. The link request holds or drops only as the completion handshake allows. Other behaviour needs the bench's scenarios: readback of each word through the bus, the one-cycle width of each pulse, and that partial or unmapped writes leave every word untouched.

// File: rtl/crac_pkg.sv
package crac_pkg;
  localparam int NUM_REGS = 4;
  localparam int REQ_BIT  = 0;
  localparam int DIR_BIT  = 1;

  typedef enum logic [1:0] {
    IDX_CTRL  = 2'd0,
    IDX_CADDR = 2'd1,
    IDX_DOUT  = 2'd2,
    IDX_DIN   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/crac_decode.sv
module crac_decode #(
  parameter int ADDR_W = 6,
  parameter int BE_W   = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              rd_any,
  output logic [1:0]        idx
);
  import crac_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word;
  logic             full;
  logic             mapped;

  always_comb begin
    word   = addr[ADDR_W-1:2];
    full   = (&be) && (addr[1:0] == 2'b00);
    mapped = (int'(word) < NUM_REGS);
    idx    = word[1:0];
    wr_ok  = sel && we && full && mapped;
    rd_ok  = sel && !we && full && mapped;
    rd_any = sel && !we;
  end
endmodule

// File: rtl/crac_regs.sv
module crac_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic              rd_any,
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] caddr,
  output logic [DATA_W-1:0] dout,
  output logic              fire_wr,
  output logic              fire_rd
);
  import crac_pkg::*;

  logic [DATA_W-1:0] word_q [NUM_REGS];
  logic              ctrl_wr;

  always_comb begin
    ctrl_wr = wr_ok && (idx == IDX_CTRL);
    fire_wr = ctrl_wr && wdata[REQ_BIT] && wdata[DIR_BIT];
    fire_rd = ctrl_wr && wdata[REQ_BIT] && !wdata[DIR_BIT];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g] <= '0;
      end else if (wr_ok && (int'(idx) == g)) begin
        if (g == int'(IDX_CTRL)) begin
          word_q[g] <= wdata & ~(DATA_W'(1) << REQ_BIT);
        end else begin
          word_q[g] <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_any) begin
      rdata <= rd_ok ? word_q[idx] : '0;
    end
  end

  assign caddr = word_q[IDX_CADDR];
  assign dout  = word_q[IDX_DOUT];

  a_r3_ctrl_keep: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == IDX_CTRL) |=>
      (word_q[IDX_CTRL] == {$past(wdata[DATA_W-1:1]), 1'b0}));

  a_r3_req_clear: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_wr) |-> !word_q[IDX_CTRL][REQ_BIT]);

  a_r7_rejected_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_any && !rd_ok) |=> (rdata == '0));

  a_r7_no_write_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(word_q[IDX_CTRL]));
endmodule

// File: rtl/crac_pulse.sv
module crac_pulse (
  input  logic clk,
  input  logic rst,
  input  logic fire_wr,
  input  logic fire_rd,
  output logic irq_wr,
  output logic irq_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_wr <= 1'b0;
      irq_rd <= 1'b0;
    end else begin
      irq_wr <= fire_wr;
      irq_rd <= fire_rd;
    end
  end

  a_r4_wr_source: assert property (@(posedge clk) disable iff (rst)
    irq_wr |-> $past(fire_wr));

  a_r5_rd_source: assert property (@(posedge clk) disable iff (rst)
    irq_rd |-> $past(fire_rd));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_wr, irq_rd}));
endmodule

// File: rtl/crac_link.sv
module crac_link (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_dir,
  input  logic done,
  output logic req,
  output logic dir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      dir <= 1'b0;
    end else if (start) begin
      req <= 1'b1;
      dir <= start_dir;
    end else if (done) begin
      req <= 1'b0;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (req && !done && !start) |=> req);

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !req);

  a_r10_dir_load: assert property (@(posedge clk) disable iff (rst)
    start |=> (req && dir == $past(start_dir)));
endmodule

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_wr_req,
  output logic              irq_rd_reply,
  output logic              link_req,
  output logic              link_dir,
  output logic [DATA_W-1:0] link_addr,
  output logic [DATA_W-1:0] link_wdata,
  input  logic              link_done
);
  logic       wr_ok, rd_ok, rd_any;
  logic [1:0] idx;
  logic       fire_wr, fire_rd;

  crac_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .be(bus_be),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_any(rd_any), .idx(idx)
  );

  crac_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_any(rd_any),
    .idx(idx), .wdata(bus_wdata), .rdata(bus_rdata),
    .caddr(link_addr), .dout(link_wdata),
    .fire_wr(fire_wr), .fire_rd(fire_rd)
  );

  crac_pulse u_pulse (
    .clk(clk), .rst(rst), .fire_wr(fire_wr), .fire_rd(fire_rd),
    .irq_wr(irq_wr_req), .irq_rd(irq_rd_reply)
  );

  crac_link u_link (
    .clk(clk), .rst(rst), .start(fire_wr || fire_rd), .start_dir(fire_wr),
    .done(link_done), .req(link_req), .dir(link_dir)
  );

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!irq_wr_req && !irq_rd_reply && !link_req && bus_rdata == '0));

  a_r6_no_pulse_without_req: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == 2'd0 && !bus_wdata[0]) |=> (!irq_wr_req && !irq_rd_reply));
endmodule

// File: tb/tb_codec_reg_ctrl.sv
module tb_codec_reg_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_wr_req, irq_rd_reply, link_req, link_dir, link_done = 1'b0;
  logic [31:0] link_addr, link_wdata;

  int checks = 0, errors = 0;
  logic p_wr, p_rd, l_wr, l_rd;
  logic [31:0] rv;

  always #2 clk = ~clk;

  codec_reg_ctrl dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_wr_req(irq_wr_req), .irq_rd_reply(irq_rd_reply),
    .link_req(link_req), .link_dir(link_dir), .link_addr(link_addr),
    .link_wdata(link_wdata), .link_done(link_done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write, then sample the pulse cycle and the cycle after it
  task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    p_wr = irq_wr_req; p_rd = irq_rd_reply;
    @(negedge clk);
    l_wr = irq_wr_req; l_rd = irq_rd_reply;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    chk("R9 rdata", bus_rdata, 0);
    chk("R9 irqs", {irq_wr_req, irq_rd_reply, link_req}, 0);
    rd(6'h00, rv); chk("R9 ctrl", rv, 0);
    rd(6'h0C, rv); chk("R9 din", rv, 0);
  endtask

  task automatic t_store();
    wr(6'h04, 32'h0000_0055); wr(6'h08, 32'hDEAD_BEEF); wr(6'h0C, 32'h1234_5678);
    rd(6'h04, rv); chk("R2 caddr", rv, 32'h55);
    rd(6'h08, rv); chk("R2 dout", rv, 32'hDEAD_BEEF);
    rd(6'h0C, rv); chk("R1 din", rv, 32'h1234_5678);
    chk("R12 link_addr", link_addr, 32'h55);
    chk("R12 link_wdata", link_wdata, 32'hDEAD_BEEF);
    chk("R6 no pulse on data write", {p_wr, p_rd}, 0);
  endtask

  task automatic t_write_req();
    wr(6'h00, 32'hA5A5_0003);
    chk("R4 wr pulse", {p_wr, p_rd}, 2'b10);
    chk("R4 one cycle", {l_wr, l_rd}, 0);
    chk("R10 req dir", {link_req, link_dir}, 2'b11);
    rd(6'h00, rv); chk("R3 ctrl", rv, 32'hA5A5_0002);
    chk("R10 hold", link_req, 1);
    @(negedge clk); link_done = 1'b1;
    @(negedge clk); link_done = 1'b0;
    chk("R10 clear", link_req, 0);
  endtask

  task automatic t_read_req();
    wr(6'h00, 32'h0000_0F01);
    chk("R5 rd pulse", {p_wr, p_rd}, 2'b01);
    chk("R5 one cycle", {l_wr, l_rd}, 0);
    chk("R10 dir read", {link_req, link_dir}, 2'b10);
    rd(6'h00, rv); chk("R3 ctrl read", rv, 32'h0000_0F00);
    @(negedge clk); link_done = 1'b1;
    @(negedge clk); link_done = 1'b0;
    chk("R10 clear read", link_req, 0);
  endtask

  task automatic t_no_req();
    wr(6'h00, 32'hFFFF_FFFE);
    chk("R6 no pulse", {p_wr, p_rd, l_wr, l_rd}, 0);
    chk("R6 no link", link_req, 0);
    rd(6'h00, rv); chk("R3 ctrl kept", rv, 32'hFFFF_FFFE);
  endtask

  task automatic t_partial();
    wr(6'h08, 32'h0BAD_0BAD, 4'h3);
    rd(6'h08, rv); chk("R7 partial write", rv, 32'hDEAD_BEEF);
    wr(6'h0A, 32'h0BAD_0BAD);
    rd(6'h08, rv); chk("R7 misaligned write", rv, 32'hDEAD_BEEF);
    wr(6'h00, 32'h3, 4'h1);
    chk("R7 partial ctrl no pulse", {p_wr, p_rd}, 0);
    rd(6'h08, rv, 4'h7); chk("R7 partial read", rv, 0);
  endtask

  task automatic t_unmapped();
    wr(6'h10, 32'hCAFE_F00D);
    wr(6'h2C, 32'hCAFE_F00D);
    rd(6'h10, rv); chk("R8 unmapped read", rv, 0);
    rd(6'h04, rv); chk("R8 caddr intact", rv, 32'h55);
    rd(6'h08, rv); chk("R8 dout intact", rv, 32'hDEAD_BEEF);
    rd(6'h0C, rv); chk("R8 din intact", rv, 32'h1234_5678);
    rd(6'h00, rv); chk("R8 ctrl intact", rv, 32'hFFFF_FFFE);
  endtask

  task automatic t_rst_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(6'h0C, rv); chk("R9 din cleared", rv, 0);
    rd(6'h04, rv); chk("R9 caddr cleared", rv, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store();
    t_write_req();
    t_read_req();
    t_no_req();
    t_partial();
    t_unmapped();
    t_rst_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule